// File: doc/BRIEF.md
# Tiled Texture Address Generator

This block turns a pixel coordinate into a byte offset inside a texture image that is stored as 64-byte microtiles. A texture uses one of two layouts. In the linear-tile layout, the microtiles simply follow each other in raster order across the image. In the hierarchical layout, sixteen microtiles form a 1 KiB subtile, and four subtiles form a 4 KiB tile. The tiles run in serpentine order: even tile rows go left to right and odd tile rows go right to left. The order of the four subtiles inside a tile also depends on the parity of the tile row.

The caller presents the following with a valid strobe:
- a pixel x and y,
- a pixel-size code,
- the image stride counted in microtiles,
- a layout select,
- the width and height of a mip level.

Two cycles later the block returns:
- the byte offset,
- an error flag for a hierarchical stride that cannot be tiled,
- a hint that says whether a mip level of the given size has to use the linear-tile layout.

A new request can be accepted on every cycle.

Top module: `tex_tile_addr_gen`

## Requirements
- R1: The pixel-size code `in_bpp` selects the bytes per pixel and the microtile shape (width x height in pixels): 0 = 1 byte, 8x8; 1 = 2 bytes, 8x4; 2 = 4 bytes, 4x4; 3 = 8 bytes, 2x4. Inside a microtile the byte offset is (row x microtile width + column) x bytes per pixel.
- R2: When `in_fmt` = 0 (linear-tile), the address is (uy x stride + ux) x 64 plus the in-microtile offset. Here ux and uy are the microtile column and row of the pixel.
- R3: When `in_fmt` = 1 (hierarchical) and the tile row ty = uy/8 is even, the tile column is tx = ux/8. The tile contributes 4096 x (ty x stride/8 + tx) to the address.
- R4: On an odd tile row the tile column is mirrored to stride/8 - ux/8 - 1.
- R5: The subtile index is 2 x bit 2 of uy plus bit 2 of ux. It selects a subtile slot, and the slot adds slot x 1024 to the address.
  - On an even tile row, indices 0, 1, 2, 3 map to slots 0, 3, 1, 2.
  - On an odd tile row, indices 0, 1, 2, 3 map to slots 2, 1, 3, 0.
- R6: Inside a subtile the microtiles are in raster order on a 4x4 grid. The microtile adds ((uy mod 4) x 4 + ux mod 4) x 64 to the address.
- R7: `out_err` is 1 only for a valid hierarchical request whose stride is not a multiple of 8. It is never set in the linear-tile layout.
- R8: Each result appears exactly 2 cycles after its request. `out_valid` repeats `in_valid` delayed by 2 cycles, and back-to-back requests give back-to-back results.
- R9: `out_use_linear` is 1 when `mip_w` is at most 4 microtile widths or `mip_h` is at most 4 microtile heights. It follows the same 2-cycle latency.
- R10: After reset, `out_valid` and `out_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_x | input | 16 | Pixel column |
| in_y | input | 16 | Pixel row |
| in_bpp | input | 2 | Pixel-size code |
| in_stride | input | 12 | Image stride in microtiles |
| in_fmt | input | 1 | 0 = linear-tile, 1 = hierarchical |
| mip_w | input | 16 | Mip level width in pixels |
| mip_h | input | 16 | Mip level height in pixels |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 32 | Byte offset |
| out_err | output | 1 | Hierarchical stride not a multiple of 8 |
| out_use_linear | output | 1 | Mip level must use the linear-tile layout |

## Verification
The assertions check on every cycle:
- the two-cycle relationship between the request and result strobes;
- that the error flag matches the stride and layout presented two cycles earlier;
- that an error is never reported without a valid result;
- that an error-free address is aligned to the pixel size.

Only the bench scenarios can show that the serpentine mirroring, the two subtile permutations, the in-subtile raster order and the mip-size thresholds produce the right byte offsets. The bench compares these offsets with a model written in divisions and remainders.

// File: rtl/tiler_pkg.sv
package tiler_pkg;

    localparam int COORD_W  = 16;
    localparam int STRIDE_W = 12;
    localparam int ADDR_W   = 32;

    typedef enum logic {
        FMT_LINEAR = 1'b0,
        FMT_HIER   = 1'b1
    } tile_fmt_e;

    // Stage-1 record carried into the address composer
    typedef struct packed {
        logic                valid;
        tile_fmt_e           fmt;
        logic                err;
        logic                use_lin;
        logic [1:0]          bpp;
        logic [1:0]          slot;
        logic [3:0]          in_sub;
        logic [5:0]          inner;
        logic [COORD_W-1:0]  tx;
        logic [COORD_W-1:0]  ty;
        logic [COORD_W-1:0]  ux;
        logic [COORD_W-1:0]  uy;
        logic [STRIDE_W-1:0] stride;
    } stage1_t;

    // log2 of the microtile width in pixels
    function automatic logic [1:0] utile_wlog(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd3;
            2'd1:    return 2'd3;
            2'd2:    return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

    // log2 of the microtile height in pixels
    function automatic logic [1:0] utile_hlog(input logic [1:0] code);
        return (code == 2'd0) ? 2'd3 : 2'd2;
    endfunction

    // Subtile permutation by tile-row parity
    function automatic logic [1:0] sub_slot(input logic odd_row, input logic [1:0] idx);
        if (odd_row) begin
            case (idx)
                2'd0:    return 2'd2;
                2'd1:    return 2'd1;
                2'd2:    return 2'd3;
                default: return 2'd0;
            endcase
        end else begin
            case (idx)
                2'd0:    return 2'd0;
                2'd1:    return 2'd3;
                2'd2:    return 2'd1;
                default: return 2'd2;
            endcase
        end
    endfunction

endpackage

// File: rtl/mip_format_pick.sv
module mip_format_pick
    import tiler_pkg::*;
#(
    parameter int CW = COORD_W
) (
    input  logic [1:0]    bpp,
    input  logic [CW-1:0] lvl_w,
    input  logic [CW-1:0] lvl_h,
    output logic          use_lin
);
    localparam int LW = CW + 1;

    logic [LW-1:0] lim_w, lim_h;

    always_comb begin
        lim_w   = LW'(4) << utile_wlog(bpp);
        lim_h   = LW'(4) << utile_hlog(bpp);
        use_lin = (LW'(lvl_w) <= lim_w) || (LW'(lvl_h) <= lim_h);
    end
endmodule

// File: rtl/tiler_decode.sv
module tiler_decode
    import tiler_pkg::*;
#(
    parameter int CW = COORD_W,
    parameter int SW = STRIDE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [CW-1:0] in_x,
    input  logic [CW-1:0] in_y,
    input  logic [1:0]    in_bpp,
    input  logic [SW-1:0] in_stride,
    input  logic          in_fmt,
    input  logic          use_lin_in,
    output stage1_t       s1
);
    logic [1:0]    wl, hl;
    logic [CW-1:0] ux, uy, tstr, tx_raw, ty;
    logic [2:0]    px, py;
    logic [5:0]    row_base;
    logic          odd_row;
    stage1_t       nxt;

    always_comb begin
        wl       = utile_wlog(in_bpp);
        hl       = utile_hlog(in_bpp);
        ux       = in_x >> wl;
        uy       = in_y >> hl;
        px       = in_x[2:0] & ((3'd1 << wl) - 3'd1);
        py       = in_y[2:0] & ((3'd1 << hl) - 3'd1);
        row_base = 6'(py) << wl;
        tstr     = CW'(in_stride >> 3);
        tx_raw   = ux >> 3;
        ty       = uy >> 3;
        odd_row  = ty[0];

        nxt.valid   = in_valid;
        nxt.fmt     = tile_fmt_e'(in_fmt);
        nxt.err     = in_valid && (tile_fmt_e'(in_fmt) == FMT_HIER) && (in_stride[2:0] != 3'd0);
        nxt.use_lin = use_lin_in;
        nxt.bpp     = in_bpp;
        nxt.slot    = sub_slot(odd_row, {uy[2], ux[2]});
        nxt.in_sub  = {uy[1:0], ux[1:0]};
        nxt.inner   = (row_base | 6'(px)) << in_bpp;
        nxt.tx      = odd_row ? (tstr - tx_raw - CW'(1)) : tx_raw;
        nxt.ty      = ty;
        nxt.ux      = ux;
        nxt.uy      = uy;
        nxt.stride  = in_stride;
    end

    always_ff @(posedge clk) begin
        if (rst) s1 <= '0;
        else     s1 <= nxt;
    end
endmodule

// File: rtl/tiler_compose.sv
module tiler_compose
    import tiler_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = STRIDE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  stage1_t       s1,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          out_err,
    output logic          out_use_linear
);
    logic [AW-1:0] tile_idx, lin_idx, hier_addr, lin_addr;
    logic [1:0]    out_bpp;

    always_comb begin
        tile_idx  = AW'(s1.ty) * AW'(s1.stride >> 3) + AW'(s1.tx);
        hier_addr = (tile_idx << 12) + (AW'(s1.slot) << 10) + (AW'(s1.in_sub) << 6) + AW'(s1.inner);
        lin_idx   = AW'(s1.uy) * AW'(s1.stride) + AW'(s1.ux);
        lin_addr  = (lin_idx << 6) + AW'(s1.inner);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_addr       <= '0;
            out_err        <= 1'b0;
            out_use_linear <= 1'b0;
            out_bpp        <= 2'd0;
        end else begin
            out_valid      <= s1.valid;
            out_addr       <= (s1.fmt == FMT_HIER) ? hier_addr : lin_addr;
            out_err        <= s1.valid && s1.err;
            out_use_linear <= s1.use_lin;
            out_bpp        <= s1.bpp;
        end
    end

    // R7
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid);

    // R1
    pixel_align_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err) |-> ((out_addr & ((AW'(1) << out_bpp) - AW'(1))) == '0));
endmodule

// File: rtl/tex_tile_addr_gen.sv
module tex_tile_addr_gen
    import tiler_pkg::*;
#(
    parameter int CW = COORD_W,
    parameter int SW = STRIDE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [CW-1:0] in_x,
    input  logic [CW-1:0] in_y,
    input  logic [1:0]    in_bpp,
    input  logic [SW-1:0] in_stride,
    input  logic          in_fmt,
    input  logic [CW-1:0] mip_w,
    input  logic [CW-1:0] mip_h,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          out_err,
    output logic          out_use_linear
);
    localparam int LAT = 2;

    logic    use_lin_c;
    stage1_t s1;

    mip_format_pick #(.CW(CW)) u_pick (
        .bpp(in_bpp), .lvl_w(mip_w), .lvl_h(mip_h), .use_lin(use_lin_c)
    );

    tiler_decode #(.CW(CW), .SW(SW)) u_decode (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_bpp(in_bpp), .in_stride(in_stride), .in_fmt(in_fmt),
        .use_lin_in(use_lin_c), .s1(s1)
    );

    tiler_compose #(.AW(AW), .SW(SW)) u_compose (
        .clk(clk), .rst(rst), .s1(s1), .out_valid(out_valid), .out_addr(out_addr),
        .out_err(out_err), .out_use_linear(out_use_linear)
    );

    // cycles since reset, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                     since_rst <= 2'd0;
        else if (since_rst != 2'(LAT)) since_rst <= since_rst + 2'd1;
    end

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'(LAT)) |-> (out_valid == $past(in_valid, 2)));

    // R7
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'(LAT)) |->
        (out_err == ($past(in_valid, 2) && $past(in_fmt, 2) && ($past(in_stride[2:0], 2) != 3'd0))));
endmodule

// File: tb/tex_tile_addr_gen_bench.sv
module tex_tile_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_x, in_y, mip_w, mip_h;
    logic [1:0]  in_bpp;
    logic [11:0] in_stride;
    logic        in_fmt;
    logic        out_valid, out_err, out_use_linear;
    logic [31:0] out_addr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tex_tile_addr_gen u_tex_tile_addr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_bpp(in_bpp), .in_stride(in_stride), .in_fmt(in_fmt),
        .mip_w(mip_w), .mip_h(mip_h), .out_valid(out_valid), .out_addr(out_addr),
        .out_err(out_err), .out_use_linear(out_use_linear)
    );

    function automatic longint ut_w(input int b);
        return (b <= 1) ? 8 : (b == 2) ? 4 : 2;
    endfunction
    function automatic longint ut_h(input int b);
        return (b == 0) ? 8 : 4;
    endfunction

    function automatic logic [31:0] model(input longint x, input longint y, input int b,
                                          input longint st, input int fmt);
        longint uw, uh, ux, uy, inner, ts, txr, ty, tx, sidx, slot, r;
        int even_map[4];
        int odd_map[4];
        even_map = '{0, 3, 1, 2};
        odd_map  = '{2, 1, 3, 0};
        uw = ut_w(b); uh = ut_h(b);
        ux = x / uw;  uy = y / uh;
        inner = ((y % uh) * uw + (x % uw)) * (64'd1 << b);
        if (fmt == 0) begin
            r = (uy * st + ux) * 64 + inner;
        end else begin
            ts = st / 8; txr = ux / 8; ty = uy / 8;
            tx = (ty % 2 == 1) ? ts - txr - 1 : txr;
            sidx = ((uy / 4) % 2) * 2 + (ux / 4) % 2;
            slot = (ty % 2 == 1) ? odd_map[sidx] : even_map[sidx];
            r = (ty * ts + tx) * 4096 + slot * 1024 + ((uy % 4) * 4 + (ux % 4)) * 64 + inner;
        end
        return r[31:0];
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive(input int x, input int y, input int b, input int st, input int f,
                         input int mw, input int mh);
        in_valid = 1'b1; in_x = 16'(x); in_y = 16'(y); in_bpp = 2'(b);
        in_stride = 12'(st); in_fmt = f[0]; mip_w = 16'(mw); mip_h = 16'(mh);
    endtask

    // one request, result sampled two edges later
    task automatic apply(input int x, input int y, input int b, input int st, input int f,
                         input int mw, input int mh);
        @(negedge clk);
        drive(x, y, b, st, f, mw, mh);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic addr_case(input string req, input int x, input int y, input int b,
                             input int st, input int f, input longint lit);
        apply(x, y, b, st, f, 64, 64);
        check(req, out_valid, 1);
        check(req, out_addr, model(x, y, b, st, f));
        if (lit >= 0) check(req, out_addr, lit);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0;
        drive(0, 0, 0, 8, 0, 64, 64); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 valid", out_valid, 0);
        check("R10 err", out_err, 0);
    endtask

    task automatic t_microtile;
        addr_case("R1 bpp4", 1, 1, 2, 16, 0, 20);
        addr_case("R1 bpp1", 7, 7, 0, 16, 0, 63);
        addr_case("R1 bpp2", 5, 3, 1, 16, 0, 58);
        addr_case("R1 bpp8", 1, 3, 3, 16, 0, 56);
    endtask

    task automatic t_linear;
        addr_case("R2 raster", 4, 4, 2, 5, 0, 384);
        addr_case("R2 wide", 37, 21, 1, 12, 0, -1);
    endtask

    task automatic t_hier_even;
        addr_case("R3 origin", 0, 0, 2, 16, 1, 0);
        addr_case("R3 tile1", 32, 0, 2, 16, 1, 4096);
        addr_case("R3 row2", 36, 70, 0, 24, 1, -1);
    endtask

    task automatic t_hier_odd;
        addr_case("R4 mirror", 0, 32, 2, 16, 1, 14336);
        addr_case("R4 last", 32, 32, 2, 16, 1, -1);
        addr_case("R4 wide", 100, 40, 1, 32, 1, -1);
    endtask

    task automatic t_subtiles;
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 4; i++)
                addr_case("R5 slot", (i % 2) * 16, p * 32 + (i / 2) * 16, 2, 16, 1, -1);
        addr_case("R5 even idx1", 16, 0, 2, 16, 1, 3072);
    endtask

    task automatic t_inner_sub;
        addr_case("R6 grid", 12, 8, 2, 16, 1, 3 * 64 + 2 * 256);
        addr_case("R6 mix", 13, 9, 2, 8, 1, -1);
    endtask

    task automatic t_err;
        apply(0, 0, 2, 12, 1, 64, 64);
        check("R7 hier bad", out_err, 1);
        apply(0, 0, 2, 16, 1, 64, 64);
        check("R7 hier good", out_err, 0);
        apply(4, 4, 2, 5, 0, 64, 64);
        check("R7 linear", out_err, 0);
        check("R7 linear addr", out_addr, model(4, 4, 2, 5, 0));
    endtask

    task automatic t_mip;
        apply(0, 0, 2, 8, 0, 16, 64); check("R9 w edge", out_use_linear, 1);
        apply(0, 0, 2, 8, 0, 17, 64); check("R9 w over", out_use_linear, 0);
        apply(0, 0, 2, 8, 0, 64, 16); check("R9 h edge", out_use_linear, 1);
        apply(0, 0, 0, 8, 0, 32, 64); check("R9 bpp1", out_use_linear, 1);
        apply(0, 0, 0, 8, 0, 33, 33); check("R9 bpp1 big", out_use_linear, 0);
        apply(0, 0, 3, 8, 0, 9, 17);  check("R9 bpp8", out_use_linear, 0);
    endtask

    task automatic t_stream;
        localparam int N = 10;
        int xs[N]; int ys[N]; int fs[N]; int vs[N];
        for (int i = 0; i < N; i++) begin
            xs[i] = i * 13; ys[i] = i * 7; fs[i] = i % 2; vs[i] = (i == 4) ? 0 : 1;
        end
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R8 valid", out_valid, vs[i-2]);
                if (vs[i-2] == 1)
                    check("R8 addr", out_addr, model(xs[i-2], ys[i-2], 1, 40, fs[i-2]));
            end
            if (i < N) begin
                drive(xs[i], ys[i], 1, 40, fs[i], 64, 64);
                in_valid = vs[i][0];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_microtile();
        t_linear();
        t_hier_even();
        t_hier_odd();
        t_subtiles();
        t_inner_sub();
        t_err();
        t_mip();
        t_stream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule